// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for a four-beat memory burst. A burst opens when one of two start strobes is asserted while the chip is selected. One strobe comes from a processor and the other from a cache controller. On that clock the external address is captured. After that, each clock with the step input high moves the burst to its next beat. The upper address bits never change during a burst. Only the two lowest bits follow the burst order, and they wrap after the fourth beat.

An ordering input picks the sequence. Low gives a counting order: the start value plus the beat number, modulo four. High gives an interleaved order: the start value XOR the beat number. The output address is registered. It changes on the clock edge that follows the load or step that caused the change. The ordering input is meant to be held steady. The output is recomputed on every clock, so the ordering input in force at that clock decides the low bits.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, `addr_o` becomes all zeros and the beat number becomes 0. The next step after reset, with no load, therefore gives address 1.
- R2: When `sel` is high and `start_proc` or `start_cache` is high, the next `addr_o` equals `addr_i` and the beat number restarts at 0.
- R3: When no load occurs and `step` is high, the beat number advances by exactly one at that clock edge.
- R4: With `order_ilv` = 0, `addr_o[1:0]` = (captured low bits + beat) mod 4.
- R5: With `order_ilv` = 1, `addr_o[1:0]` = captured low bits XOR beat.
- R6: After four beats the low bits return to the captured start value. `addr_o[ADDR_W-1:2]` changes only through a load and never receives a carry from the low bits.
- R7: A load in the middle of a burst restarts the sequence from the new address. A load takes priority over `step` in the same cycle.
- R8: When there is no load and `step` is low, `addr_o` holds its value (wait state), provided `order_ilv` is unchanged.
- R9: Either strobe with `sel` low is ignored: no address is captured. `step` still acts on the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | External address captured by a load |
| sel | input | 1 | Chip select; both strobes need it |
| start_proc | input | 1 | Processor start strobe, active high |
| start_cache | input | 1 | Cache-controller start strobe, active high |
| step | input | 1 | Advance to the next beat, active high |
| order_ilv | input | 1 | 0 = counting order, 1 = interleaved order |
| addr_o | output | ADDR_W | Registered burst address |

## Verification
The hardest situation to reach is a burst already under way that meets a strobe without chip select. In that cycle the burst must keep its captured base, and a step in the same cycle must still advance it. A related case is the low bits wrapping from 3 to 0 while the upper bits sit at all ones, which is where a stray carry would show. The stimulus table walks a full counting burst and a full interleaved burst into their wrap-around. It then sends deselected strobes carrying an all-ones address, with and without a step. Finally it reloads all ones and steps once, so that any carry or any wrongly captured address shows up in the upper bits.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Burst ordering selected by the order input
  typedef enum logic {
    ORD_COUNT      = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  // What the sequencer does on a given clock
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } seq_action_e;

endpackage

// File: rtl/seq_load_ctrl.sv
module seq_load_ctrl
  import burst_pkg::*;
(
  input  logic        sel,
  input  logic        start_proc,
  input  logic        start_cache,
  input  logic        step,
  output seq_action_e action
);

  logic proc_take;
  logic cache_take;

  // Each strobe is honoured only while the chip is selected
  assign proc_take  = start_proc  & sel;
  assign cache_take = start_cache & sel;

  always_comb begin
    if (proc_take || cache_take) begin
      action = ACT_LOAD;   // a load outranks a step
    end else if (step) begin
      action = ACT_STEP;
    end else begin
      action = ACT_HOLD;
    end
  end

endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_pkg::*;
#(
  parameter int COUNT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  seq_action_e        action,
  output logic [COUNT_W-1:0] beat_d,
  output logic [COUNT_W-1:0] beat_q
);

  always_comb begin
    unique case (action)
      ACT_LOAD: beat_d = '0;
      ACT_STEP: beat_d = beat_q + COUNT_W'(1);
      default:  beat_d = beat_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
    end else begin
      beat_q <= beat_d;
    end
  end

  // R7: a load always resets the beat number
  assert_load_restarts_R7: assert property (@(posedge clk) disable iff (rst)
    (action == ACT_LOAD) |=> (beat_q == '0));

  // R3: a step without a load moves exactly one beat
  assert_step_one_beat_R3: assert property (@(posedge clk) disable iff (rst)
    (action == ACT_STEP) |=> (beat_q == $past(beat_q) + COUNT_W'(1)));

  // R8: no load and no step leaves the beat alone
  assert_hold_beat_R8: assert property (@(posedge clk) disable iff (rst)
    (action == ACT_HOLD) |=> $stable(beat_q));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int COUNT_W = 2
) (
  input  logic [COUNT_W-1:0] start_lo,
  input  logic [COUNT_W-1:0] beat,
  input  burst_order_e       order,
  output logic [COUNT_W-1:0] lo_out
);

  logic [COUNT_W-1:0] count_lo;
  logic [COUNT_W-1:0] ilv_lo;

  // Counting order: modular sum, carries dropped at the top bit
  assign count_lo = start_lo + beat;

  // Interleaved order: each bit flipped by the matching beat bit
  for (genvar b = 0; b < COUNT_W; b++) begin : g_ilv
    assign ilv_lo[b] = start_lo[b] ^ beat[b];
  end

  assign lo_out = (order == ORD_INTERLEAVE) ? ilv_lo : count_lo;

  // R5/R4: the first beat of either order is the start value itself
  always_comb begin
    if (beat == '0) begin
      assert_beat0_is_start_R4: assert (lo_out == start_lo);
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int COUNT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel,
  input  logic              start_proc,
  input  logic              start_cache,
  input  logic              step,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int HI_W = ADDR_W - COUNT_W;

  seq_action_e        action;
  logic [COUNT_W-1:0] beat_d;
  logic [COUNT_W-1:0] beat_q;
  logic [ADDR_W-1:0]  base_q;
  logic [ADDR_W-1:0]  base_d;
  logic [COUNT_W-1:0] lo_next;
  burst_order_e       order;

  assign order = burst_order_e'(order_ilv);

  seq_load_ctrl u_ctrl (
    .sel         (sel),
    .start_proc  (start_proc),
    .start_cache (start_cache),
    .step        (step),
    .action      (action)
  );

  burst_beat_counter #(.COUNT_W(COUNT_W)) u_beat (
    .clk    (clk),
    .rst    (rst),
    .action (action),
    .beat_d (beat_d),
    .beat_q (beat_q)
  );

  // Captured base: upper bits plus start value of the low bits
  assign base_d = (action == ACT_LOAD) ? addr_i : base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else begin
      base_q <= base_d;
    end
  end

  burst_order_map #(.COUNT_W(COUNT_W)) u_map (
    .start_lo (base_d[COUNT_W-1:0]),
    .beat     (beat_d),
    .order    (order),
    .lo_out   (lo_next)
  );

  // Registered output built from next-state values
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
    end else begin
      addr_o <= {base_d[ADDR_W-1:COUNT_W], lo_next};
    end
  end

  // R2: a load places the external address on the output next cycle
  assert_load_to_out_R2: assert property (@(posedge clk) disable iff (rst)
    (sel && (start_proc || start_cache)) |=> (addr_o == $past(addr_i)));

  // R6: upper bits never move without a load
  assert_no_carry_R6: assert property (@(posedge clk) disable iff (rst)
    !(sel && (start_proc || start_cache))
      |=> (addr_o[ADDR_W-1:COUNT_W] == $past(addr_o[ADDR_W-1:COUNT_W])));

  // R8: wait state holds the address while the order is unchanged
  assert_wait_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!(sel && (start_proc || start_cache)) && !step)
      |=> ((order_ilv != $past(order_ilv)) || $stable(addr_o)));

  // R9: a deselected strobe does not capture the base
  assert_deselect_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (!sel) |=> $stable(base_q));

  // Base and output must agree in the upper field at all times
  assert_base_matches_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (addr_o[ADDR_W-1:COUNT_W] == base_q[ADDR_W-1:COUNT_W]));

  logic unused_hi;
  assign unused_hi = ^{HI_W};

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int  ADDR_W = 18;
  localparam time PERIOD = 20ns;
  localparam int  NVEC   = 19;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              sel = 1'b0;
  logic              start_proc = 1'b0;
  logic              start_cache = 1'b0;
  logic              step = 1'b0;
  logic              order_ilv = 1'b0;
  logic [ADDR_W-1:0] addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
    .clk         (clk),
    .rst         (rst),
    .addr_i      (addr_i),
    .sel         (sel),
    .start_proc  (start_proc),
    .start_cache (start_cache),
    .step        (step),
    .order_ilv   (order_ilv),
    .addr_o      (addr_o)
  );

  // {req[3:0], start_proc, start_cache, sel, step, order_ilv, addr_i, expected}
  localparam logic [44:0] VECS [NVEC] = '{
    {4'd2, 5'b01100, 18'h12345, 18'h12345},  // R2 cache strobe load
    {4'd4, 5'b00010, 18'h00000, 18'h12346},  // R4 counting beat 1
    {4'd4, 5'b00010, 18'h00000, 18'h12347},  // R4 beat 2
    {4'd6, 5'b00010, 18'h00000, 18'h12344},  // R6 low bits wrap, no carry
    {4'd6, 5'b00010, 18'h00000, 18'h12345},  // R6 back to start
    {4'd8, 5'b00000, 18'h00000, 18'h12345},  // R8 wait state
    {4'd2, 5'b10101, 18'h0ABC6, 18'h0ABC6},  // R2 processor strobe load
    {4'd5, 5'b00011, 18'h00000, 18'h0ABC7},  // R5 10^01
    {4'd5, 5'b00011, 18'h00000, 18'h0ABC4},  // R5 10^10
    {4'd5, 5'b00011, 18'h00000, 18'h0ABC5},  // R5 10^11
    {4'd8, 5'b00001, 18'h00000, 18'h0ABC5},  // R8 wait in interleaved burst
    {4'd6, 5'b00011, 18'h00000, 18'h0ABC6},  // R6 interleaved wrap
    {4'd9, 5'b10001, 18'h3FFFF, 18'h0ABC6},  // R9 deselected processor strobe
    {4'd9, 5'b10011, 18'h3FFFF, 18'h0ABC7},  // R9 step still acts
    {4'd9, 5'b01001, 18'h00000, 18'h0ABC7},  // R9 deselected cache strobe
    {4'd7, 5'b01100, 18'h3FFFF, 18'h3FFFF},  // R7 mid-burst restart
    {4'd6, 5'b00010, 18'h00000, 18'h3FFFC},  // R6 no carry out of all ones
    {4'd7, 5'b11110, 18'h00001, 18'h00001},  // R7 load beats step
    {4'd3, 5'b00010, 18'h00000, 18'h00002}   // R3 single step
  };

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    checks++;
    if (addr_o !== exp) begin
      fails++;
      $display("FAIL %s: addr_o=%h expected %h", req, addr_o, exp);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [ADDR_W-1:0] a);
    {start_proc, start_cache, sel, step, order_ilv} = c;
    addr_i = a;
  endtask

  initial begin
    // Reset for two edges, inputs change on falling edges only
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", '0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i][40:36], VECS[i][35:18]);
      @(negedge clk);
      check($sformatf("R%0d", VECS[i][44:41]), VECS[i][17:0]);
    end

    // R1: reset in the middle of a burst clears the address
    drive(5'b00010, '0);
    rst = 1'b1;
    @(negedge clk);
    check("R1", '0);
    rst = 1'b0;
    // R1/R3: first step after reset starts from beat 0 of base 0
    @(negedge clk);
    check("R3", 18'h00001);

    drive(5'b00000, '0);
    @(negedge clk);
    check("R8", 18'h00001);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 2000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule